// File: doc/BRIEF.md
# Windowed Dead-Man Timer

This block watches that software keeps making progress. Once running, it counts up by one every clock. Software must send a clear request to restart the count. A clear is accepted only while the count sits inside an allowed window. The window opens at a fraction of the terminal count and stays open up to it. If the count reaches the terminal value first, or a clear arrives before the window opens, the block raises a one-cycle event pulse. Other logic sends that pulse on to reset or trap handling; that routing is not part of this block.

The terminal count is a power of two picked by a count-select code. The window start is picked by an interval code. Interval code k removes the top 1/2^k of the count range, so the window opens at T − T/2^k. Interval code 0 turns windowing off, and then a clear is accepted at any count. The timer runs when the configuration enable or the software ON bit is high.

Top module: `dmt_window_timer`

## Requirements
- R1: Count-select code n below NUM_CODES (default 24) gives a terminal count T = 2^(MIN_EXP+n) (default MIN_EXP = 8, so 2^8 to 2^31). Select codes take effect one cycle after they are applied.
- R2: Count-select codes of NUM_CODES and above (24 to 31 by default) behave as the largest legal code, T = 2^(MIN_EXP+NUM_CODES−1).
- R3: With interval code 0 the window start is 0: `win_open_o` is high whenever the timer runs, and a clear is accepted at any count.
- R4: With interval code k from 1 to 7, the window start is T − (T >> k). While running, `win_open_o` is high exactly when `count_o` is at or above that start.
- R5: The timer runs when `cfg_en_i` or `sw_on_i` is 1. When both are 0, `count_o` is 0 from the next cycle, `win_open_o` is 0, and `clr_i` raises no event.
- R6: After reset or a restart the count is 0. While running it rises by one per clock.
- R7: A clear request while the window is open sets `count_o` to 0 on the next cycle and raises no event.
- R8: A clear request while the count is below the window start raises `event_o` for one cycle and does not restart the count.
- R9: When the count steps to T, `event_o` pulses for one cycle in that same cycle. The count then holds at T, with no further event, until a valid clear, a disable or reset.
- R10: If a clear request and the step to T fall in the same cycle, an in-window clear wins (count 0, no event). An early clear gives a single event pulse, and the count still reaches T.
- R11: Synchronous active-high reset leaves `count_o` at 0 and `event_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en_i | input | 1 | Enable from configuration |
| sw_on_i | input | 1 | Software ON bit; used when cfg_en_i is 0 |
| cnt_sel_i | input | SEL_W (5) | Terminal count select code |
| intv_sel_i | input | INTV_W (3) | Window interval code |
| clr_i | input | 1 | Clear request from software |
| count_o | output | MIN_EXP+NUM_CODES (32) | Current count |
| win_open_o | output | 1 | Clear window is open |
| event_o | output | 1 | One-cycle pulse on timeout or early clear |

## Verification
A clear request and the step to the terminal count can fall in the same cycle. The bench provokes this with a reduced configuration: for every count code and every interval code, it asserts a single clear at count T−1. When T−1 is inside the window, the result must be a count of 0 with no event. When the window opens only at T, the early clear and the timeout must merge into one event, and the count must sit at T. The same sweep also places the clear at every other count from 0 to T, so both window edges are covered for each code pair.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  // Action taken by the counter on the next clock edge
  typedef enum logic [2:0] {
    ACT_OFF,      // not running: count parked at zero
    ACT_STEP,     // normal increment
    ACT_RESTART,  // accepted clear
    ACT_EXPIRE,   // step onto the terminal count
    ACT_HOLD      // expired, waiting for a clear
  } dmt_act_e;

endpackage

// File: rtl/dmt_limit_decode.sv
module dmt_limit_decode #(
  parameter int MIN_EXP   = 8,
  parameter int NUM_CODES = 24,
  parameter int SEL_W     = 5,
  parameter int INTV_W    = 3,
  parameter int CNT_W     = MIN_EXP + NUM_CODES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  cnt_sel_i,
  input  logic [INTV_W-1:0] intv_sel_i,
  output logic [CNT_W-1:0]  term_o,
  output logic [CNT_W-1:0]  wstart_o
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(NUM_CODES - 1);

  logic [SEL_W-1:0] eff_code;
  logic [CNT_W-1:0] term_d;
  logic [CNT_W-1:0] wstart_d;

  // Reserved codes fold onto the largest legal one
  always_comb begin
    eff_code = (cnt_sel_i > TOP_CODE) ? TOP_CODE : cnt_sel_i;
    term_d   = ONE << (MIN_EXP + int'(eff_code));
    if (intv_sel_i == '0) wstart_d = '0;
    else                  wstart_d = term_d - (term_d >> intv_sel_i);
  end

  // Registered so the shift and subtract stay out of the counter path
  always_ff @(posedge clk) begin
    term_o   <= term_d;
    wstart_o <= wstart_d;
  end

  AST_TERM_POW2: assert property (@(posedge clk) disable iff (rst)
    $onehot(term_o)) else $error("terminal count not a power of two"); // R1

  AST_WSTART_BELOW_TERM: assert property (@(posedge clk) disable iff (rst)
    wstart_o <= term_o) else $error("window start above terminal"); // R4

endmodule

// File: rtl/dmt_core.sv
module dmt_core
  import dmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] term_i,
  input  logic [CNT_W-1:0] wstart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             win_o,
  output logic             evt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             evt_q;
  logic             in_win;
  logic             early;
  dmt_act_e         act;

  assign in_win = (cnt_q >= wstart_i);
  assign early  = run_i && clr_i && !in_win;

  always_comb begin
    if (!run_i)                         act = ACT_OFF;
    else if (clr_i && in_win)           act = ACT_RESTART;
    else if (exp_q)                     act = ACT_HOLD;
    else if (cnt_q >= term_i - 1'b1)    act = ACT_EXPIRE;
    else                                act = ACT_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= early || (act == ACT_EXPIRE);
      case (act)
        ACT_OFF, ACT_RESTART: begin
          cnt_q <= '0;
          exp_q <= 1'b0;
        end
        ACT_EXPIRE: begin
          cnt_q <= term_i;
          exp_q <= 1'b1;
        end
        ACT_STEP: cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign win_o = run_i && in_win;
  assign evt_o = evt_q;

  AST_VALID_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run_i && clr_i && win_o) |=> (cnt_q == '0) && !evt_q) else $error("accepted clear"); // R7

  AST_EARLY_CLR_EVT: assert property (@(posedge clk) disable iff (rst)
    (run_i && clr_i && !win_o) |=> evt_q) else $error("early clear"); // R8

  AST_EXPIRED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_i && exp_q && !clr_i) |=> $stable(cnt_q) && !evt_q) else $error("hold"); // R9

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0) && !evt_q) else $error("disabled"); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_i && !clr_i && !exp_q && (cnt_q + 1'b1 < term_i))
      |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("step"); // R6

endmodule

// File: rtl/dmt_window_timer.sv
module dmt_window_timer #(
  parameter int MIN_EXP   = 8,
  parameter int NUM_CODES = 24,
  parameter int SEL_W     = 5,
  parameter int INTV_W    = 3,
  localparam int CNT_W    = MIN_EXP + NUM_CODES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en_i,
  input  logic              sw_on_i,
  input  logic [SEL_W-1:0]  cnt_sel_i,
  input  logic [INTV_W-1:0] intv_sel_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              win_open_o,
  output logic              event_o
);

  logic             run;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] wstart;

  // Configuration enable takes precedence; software ON covers the other case
  assign run = cfg_en_i | sw_on_i;

  dmt_limit_decode #(
    .MIN_EXP  (MIN_EXP),
    .NUM_CODES(NUM_CODES),
    .SEL_W    (SEL_W),
    .INTV_W   (INTV_W),
    .CNT_W    (CNT_W)
  ) u_decode (
    .clk       (clk),
    .rst       (rst),
    .cnt_sel_i (cnt_sel_i),
    .intv_sel_i(intv_sel_i),
    .term_o    (term),
    .wstart_o  (wstart)
  );

  dmt_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run),
    .clr_i   (clr_i),
    .term_i  (term),
    .wstart_i(wstart),
    .cnt_o   (count_o),
    .win_o   (win_open_o),
    .evt_o   (event_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (count_o == '0) && !event_o) else $error("reset state"); // R11

endmodule

// File: tb/tb_dmt_window_timer.sv
`timescale 1ns/1ps
module tb_dmt_window_timer;

  localparam int MIN_EXP   = 2;
  localparam int NUM_CODES = 4;
  localparam int CNT_W     = MIN_EXP + NUM_CODES;
  localparam int WD_LIMIT  = 190000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_en = 1'b0;
  logic             sw_on = 1'b0;
  logic [4:0]       cnt_sel = '0;
  logic [2:0]       intv_sel = '0;
  logic             clr = 1'b0;
  logic [CNT_W-1:0] count;
  logic             win_open;
  logic             evt;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dmt_window_timer #(
    .MIN_EXP  (MIN_EXP),
    .NUM_CODES(NUM_CODES)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_en_i  (cfg_en),
    .sw_on_i   (sw_on),
    .cnt_sel_i (cnt_sel),
    .intv_sel_i(intv_sel),
    .clr_i     (clr),
    .count_o   (count),
    .win_open_o(win_open),
    .event_o   (evt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Run c cycles from reset, then one clear request, and check each stage
  task automatic run_case(input int sel, input int iv, input int c, input bit use_cfg);
    int    t, ws, evts, expc;
    string rt, wt;
    t  = 1 << (MIN_EXP + ((sel >= NUM_CODES) ? NUM_CODES - 1 : sel));
    ws = (iv == 0) ? 0 : t - (t >> iv);
    rt = (sel >= NUM_CODES) ? "R2" : "R1";
    wt = (iv == 0) ? "R3" : "R4";
    cnt_sel  = 5'(sel);
    intv_sel = 3'(iv);
    cfg_en   = use_cfg;
    sw_on    = !use_cfg;
    do_reset();
    if (c == 0) begin
      chk("R11 count after reset", count, 0);
      chk("R11 event after reset", evt, 0);
    end
    evts = 0;
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      if (evt) evts++;
    end
    expc = (c < t) ? c : t;
    chk((c < t) ? "R6 count" : {rt, " R9 count at terminal"}, count, expc);
    chk({rt, " R9 timeout events"}, evts, (c >= t) ? 1 : 0);
    chk({wt, " window flag"}, win_open, (c >= ws) ? 1 : 0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    if (c >= ws) begin
      chk((c == t - 1) ? "R10 in-window clear count" : "R7 clear count", count, 0);
      chk((c == t - 1) ? "R10 in-window clear event" : "R7 clear event", evt, 0);
    end else begin
      chk((c == t - 1) ? "R10 early clear at terminal count" : "R8 early clear count",
          count, (c + 1 < t) ? c + 1 : t);
      chk((c == t - 1) ? "R10 early clear at terminal event" : "R8 early clear event", evt, 1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int evts;
    do_reset();

    // Full sweep: all select codes incl. reserved, all interval codes, every clear point
    for (int sel = 0; sel < 8; sel++)
      for (int iv = 0; iv < 8; iv++) begin
        int t;
        t = 1 << (MIN_EXP + ((sel >= NUM_CODES) ? NUM_CODES - 1 : sel));
        for (int c = 0; c <= t; c++)
          run_case(sel, iv, c, ((sel + iv + c) % 2) == 1);
      end

    // Hold at terminal: T = 8, long run, exactly one event
    cnt_sel = 5'd1; intv_sel = 3'd1; cfg_en = 1'b1; sw_on = 1'b0;
    do_reset();
    evts = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (evt) evts++;
    end
    chk("R9 held count", count, 8);
    chk("R9 single timeout pulse", evts, 1);

    // Disable: both enables low, clears ignored
    cfg_en = 1'b0; sw_on = 1'b0;
    evts = 0;
    for (int i = 0; i < 10; i++) begin
      clr = i[0];
      @(negedge clk);
      if (evt) evts++;
    end
    clr = 1'b0;
    chk("R5 disabled count", count, 0);
    chk("R5 disabled window", win_open, 0);
    chk("R5 disabled events", evts, 0);

    // Software ON alone runs the timer
    sw_on = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk("R5 software on count", count, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule